// File: doc/BRIEF.md
# Early-Out Iterative Integer Divider

This block divides one 32-bit dividend by one 32-bit divisor, as unsigned or as two's-complement signed numbers, and returns a quotient (the LO result) and a remainder (the HI result). It is a radix-2 restoring divider that settles one quotient bit on each clock. Before it starts iterating, it looks at how far the dividend is sign-extended (or zero-extended). It then runs only 8, 16, 24 or 32 iterations, so a small dividend finishes sooner.

A request is offered with `req_valid` and is taken on a rising edge where `req_ready` is also high. `req_ready` is low for the whole of a divide, so the requester is held off until the running divide ends. The result side has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_quotient` and `rsp_remainder` in that cycle or later. Both stay unchanged until the next pulse.

In signed mode the block spends one extra cycle taking magnitudes and one extra cycle restoring signs. A zero divisor does not trap or hang. It completes after the normal latency with a fixed result.

Top module: `div_early_out`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and `rsp_quotient` and `rsp_remainder` are 0.
- R2: In unsigned mode (`req_signed`=0) with a nonzero divisor, the quotient is floor(dividend/divisor) and the remainder is dividend minus quotient times divisor.
- R3: In signed mode (`req_signed`=1) with a nonzero divisor, the quotient is truncated toward zero: it is negative when exactly one operand is negative. The remainder carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: The iteration count k is the smallest value in {8,16,24,32} for which the dividend is representable in k bits. In unsigned mode that means dividend < 2^k. In signed mode it means -2^(k-1) <= dividend < 2^(k-1).
- R5: In unsigned mode, `rsp_valid` is first high after the (k+3)-th rising edge that follows the accepting edge. Counting the accept cycle, that is 12, 20, 28 or 36 cycles for k = 8, 16, 24 or 32.
- R6: Signed mode adds exactly two cycles to the R5 latency, giving 14, 22, 30 or 38.
- R7: `req_ready` is 0 from the accepting edge until the cycle in which `rsp_valid` is high. In that cycle `req_ready` is 1 again. A `req_valid` presented while `req_ready` is 0 is not taken and does not change the result in flight.
- R8: `rsp_valid` lasts exactly one cycle. `rsp_quotient` and `rsp_remainder` change only in a cycle where `rsp_valid` is high.
- R9: A zero divisor, in either mode, gives quotient 0xFFFFFFFF and a remainder equal to the raw dividend. The latency is the same as R5/R6 for that dividend's class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_dividend | input | 32 | Dividend |
| req_divisor | input | 32 | Divisor |
| req_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_quotient | output | 32 | Quotient (LO) |
| rsp_remainder | output | 32 | Remainder (HI) |

## Verification
The result of each divide is due after the (k+3)-th rising edge past the accepting edge, or the (k+5)-th in signed mode. k comes from the dividend's class. The bench derives k by comparing the dividend against the class bounds, then counts edges from acceptance while sampling at falling edges. It requires the pulse on exactly that count, and it requires `req_ready` to stay low on every count before it. On the pulse it compares quotient and remainder against values from the bench's own integer arithmetic. One cycle later it confirms that the pulse has ended and that the outputs are unchanged. A held request behind a running divide is checked to be taken only on the edge after the pulse.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ABS   = 3'd1,
    ST_CLASS = 3'd2,
    ST_ALIGN = 3'd3,
    ST_ITER  = 3'd4,
    ST_FIX   = 3'd5,
    ST_OUT   = 3'd6
  } div_state_e;

endpackage

// File: rtl/div_width_class.sv
// Chooses the narrowest segment multiple that holds the dividend.
module div_width_class #(
  parameter int W   = 32,
  parameter int SEG = 8,
  localparam int NSEG = W / SEG,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  input  logic          signed_mode,
  output logic [CW-1:0] width
);

  logic [NSEG-1:0] fits;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int K = (s + 1) * SEG;
    if (K >= W) begin : g_full
      assign fits[s] = 1'b1;
    end else begin : g_part
      logic sx_ok;
      logic zx_ok;
      assign sx_ok   = (&value[W-1:K-1]) | ~(|value[W-1:K-1]);
      assign zx_ok   = ~(|value[W-1:K]);
      assign fits[s] = signed_mode ? sx_ok : zx_ok;
    end
  end

  always_comb begin
    width = CW'(W);
    for (int s = NSEG - 1; s >= 0; s--) begin
      if (fits[s]) width = CW'((s + 1) * SEG);
    end
  end

endmodule

// File: rtl/div_step.sv
// One restoring radix-2 step: shift in a dividend bit, trial subtract.
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W:0] shifted;
  logic [W:0] trial;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    trial   = shifted - {1'b0, dvs_i};
    if (!trial[W]) begin
      rem_o = trial[W-1:0];
      quo_o = {quo_i[W-2:0], 1'b1};
    end else begin
      rem_o = shifted[W-1:0];
      quo_o = {quo_i[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/div_cneg.sv
// Conditional two's-complement negation.
module div_cneg #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_v,
  input  logic         neg,
  output logic [W-1:0] out_v
);

  assign out_v = neg ? (~in_v + W'(1)) : in_v;

endmodule

// File: rtl/div_early_out.sv
module div_early_out
  import div_pkg::*;
#(
  parameter int W   = 32,
  parameter int SEG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_dividend,
  input  logic [W-1:0] req_divisor,
  input  logic         req_signed,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_quotient,
  output logic [W-1:0] rsp_remainder
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] WC = CW'(W);

  div_state_e    state;
  logic [W-1:0]  dvd_raw;
  logic [W-1:0]  dvs_raw;
  logic          sgn_mode;
  logic [W-1:0]  mag_dvs;
  logic [W-1:0]  q_r;
  logic [W-1:0]  r_r;
  logic [CW-1:0] cnt;
  logic [CW-1:0] kcls;
  logic [CW-1:0] cls_w;
  logic [W-1:0]  step_q;
  logic [W-1:0]  step_r;
  logic          accept;
  logic          fix_phase;
  logic          q_neg;
  logic          r_neg;

  logic [W-1:0]  neg_in  [2];
  logic [W-1:0]  neg_out [2];
  logic          neg_en  [2];

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign fix_phase = (state == ST_FIX);
  assign q_neg     = sgn_mode & (dvd_raw[W-1] ^ dvs_raw[W-1]);
  assign r_neg     = sgn_mode & dvd_raw[W-1];

  // Two negators are shared between the magnitude phase and the sign-fix phase.
  always_comb begin
    neg_in[0] = fix_phase ? q_r : dvd_raw;
    neg_en[0] = fix_phase ? q_neg : (sgn_mode & dvd_raw[W-1]);
    neg_in[1] = fix_phase ? r_r : dvs_raw;
    neg_en[1] = fix_phase ? r_neg : (sgn_mode & dvs_raw[W-1]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_neg
    div_cneg #(.W(W)) u_neg (
      .in_v  (neg_in[g]),
      .neg   (neg_en[g]),
      .out_v (neg_out[g])
    );
  end

  div_width_class #(.W(W), .SEG(SEG)) u_class (
    .value       (dvd_raw),
    .signed_mode (sgn_mode),
    .width       (cls_w)
  );

  div_step #(.W(W)) u_step (
    .rem_i (r_r),
    .quo_i (q_r),
    .dvs_i (mag_dvs),
    .rem_o (step_r),
    .quo_o (step_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      dvd_raw       <= '0;
      dvs_raw       <= '0;
      sgn_mode      <= 1'b0;
      mag_dvs       <= '0;
      q_r           <= '0;
      r_r           <= '0;
      cnt           <= '0;
      kcls          <= '0;
      rsp_valid     <= 1'b0;
      rsp_quotient  <= '0;
      rsp_remainder <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            dvd_raw  <= req_dividend;
            dvs_raw  <= req_divisor;
            sgn_mode <= req_signed;
            mag_dvs  <= req_divisor;
            q_r      <= req_dividend;
            state    <= req_signed ? ST_ABS : ST_CLASS;
          end
        end
        ST_ABS: begin
          q_r     <= neg_out[0];
          mag_dvs <= neg_out[1];
          state   <= ST_CLASS;
        end
        ST_CLASS: begin
          kcls  <= cls_w;
          state <= ST_ALIGN;
        end
        ST_ALIGN: begin
          q_r   <= q_r << (WC - kcls);
          r_r   <= '0;
          cnt   <= kcls;
          state <= ST_ITER;
        end
        ST_ITER: begin
          q_r <= step_q;
          r_r <= step_r;
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= sgn_mode ? ST_FIX : ST_OUT;
        end
        ST_FIX: begin
          q_r   <= neg_out[0];
          r_r   <= neg_out[1];
          state <= ST_OUT;
        end
        ST_OUT: begin
          rsp_valid <= 1'b1;
          if (dvs_raw == '0) begin
            rsp_quotient  <= '1;
            rsp_remainder <= dvd_raw;
          end else begin
            rsp_quotient  <= q_r;
            rsp_remainder <= r_r;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: an accepted request closes the request side on the next cycle.
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7: the request side reopens together with the result pulse.
  p_ready_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R8: the result pulse is a single cycle.
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: result registers move only with the pulse.
  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rsp_quotient) || !$stable(rsp_remainder)) |-> rsp_valid);

  // R4: the iteration window is a nonzero segment multiple.
  p_class_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGN) |-> (kcls != '0 && kcls <= WC && (int'(kcls) % SEG) == 0));

  // R5: the iteration counter never leaves its window.
  p_iter_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER) |-> (cnt != '0 && cnt <= kcls));

  // R6: the sign-fix phase happens only in signed mode and only after iterating.
  p_fix_signed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |-> (sgn_mode && $past(state) == ST_ITER));

endmodule

// File: tb/sim_div_early_out.sv
`timescale 1ns/1ps
module sim_div_early_out;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_dividend = '0;
  logic [31:0] req_divisor = '0;
  logic        req_signed = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_quotient;
  logic [31:0] rsp_remainder;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  div_early_out u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_dividend  (req_dividend),
    .req_divisor   (req_divisor),
    .req_signed    (req_signed),
    .rsp_valid     (rsp_valid),
    .rsp_quotient  (rsp_quotient),
    .rsp_remainder (rsp_remainder)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int class_k(input logic [31:0] a, input bit sg);
    int sa;
    sa = $signed(a);
    if (sg) begin
      if (sa >= -128 && sa <= 127) return 8;
      if (sa >= -32768 && sa <= 32767) return 16;
      if (sa >= -8388608 && sa <= 8388607) return 24;
      return 32;
    end
    if (a < 32'd256) return 8;
    if (a < 32'd65536) return 16;
    if (a < 32'd16777216) return 24;
    return 32;
  endfunction

  function automatic int exp_edges(input logic [31:0] a, input bit sg);
    return class_k(a, sg) + 3 + (sg ? 2 : 0);
  endfunction

  task automatic expect_res(input logic [31:0] a, input logic [31:0] b, input bit sg,
                            output logic [31:0] q, output logic [31:0] r);
    if (b == 32'd0) begin
      q = 32'hFFFF_FFFF;
      r = a;
    end else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000;
      r = 32'd0;
    end else if (sg) begin
      q = 32'($signed(a) / $signed(b));
      r = 32'($signed(a) % $signed(b));
    end else begin
      q = a / b;
      r = a % b;
    end
  endtask

  function automatic string tag_of(input logic [31:0] b, input bit sg);
    if (b == 32'd0) return "R9";
    return sg ? "R3" : "R2";
  endfunction

  // Counts edges after acceptance until the pulse; checks busy along the way.
  task automatic wait_result(output int n, output bit busy_ok);
    n = 0;
    busy_ok = 1'b1;
    forever begin
      if (rsp_valid) break;
      if (req_ready) busy_ok = 1'b0;
      if (n > 100) break;
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(input logic [31:0] a, input logic [31:0] b, input bit sg,
                              input int n, input bit busy_ok);
    logic [31:0] eq, er;
    string t;
    expect_res(a, b, sg, eq, er);
    t = tag_of(b, sg);
    chk(n == exp_edges(a, sg), sg ? "R6 latency" : "R5 latency", n, exp_edges(a, sg));
    chk(busy_ok, "R7 ready low while busy", 0, 1);
    chk(req_ready, "R7 ready with pulse", req_ready, 1);
    chk(rsp_quotient == eq, {t, " quotient"}, rsp_quotient, eq);
    chk(rsp_remainder == er, {t, " remainder"}, rsp_remainder, er);
  endtask

  task automatic one_div(input logic [31:0] a, input logic [31:0] b, input bit sg);
    int n;
    bit busy_ok;
    logic [31:0] hq, hr;
    while (!req_ready) @(negedge clk);
    req_dividend = a;
    req_divisor  = b;
    req_signed   = sg;
    req_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(n, busy_ok);
    check_result(a, b, sg, n, busy_ok);
    hq = rsp_quotient;
    hr = rsp_remainder;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R8 pulse length", rsp_valid, 0);
    chk(rsp_quotient == hq && rsp_remainder == hr, "R8 hold", rsp_quotient, hq);
  endtask

  // A second request held high during a divide is taken only after the pulse.
  task automatic back_to_back(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] a2, input logic [31:0] b2, input bit sg);
    int n;
    bit busy_ok;
    while (!req_ready) @(negedge clk);
    req_dividend = a;
    req_divisor  = b;
    req_signed   = sg;
    req_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_dividend = a2;
    req_divisor  = b2;
    wait_result(n, busy_ok);
    check_result(a, b, sg, n, busy_ok);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7 held request taken after pulse", req_ready, 0);
    wait_result(n, busy_ok);
    check_result(a2, b2, sg, n, busy_ok);
  endtask

  localparam logic [31:0] DVD [22] = '{
    32'd0, 32'd1, 32'd127, 32'd128, 32'd255, 32'd256, 32'd32767, 32'd32768,
    32'd65535, 32'd65536, 32'h007F_FFFF, 32'h0080_0000, 32'h00FF_FFFF, 32'h0100_0000,
    32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hFFFF_FF7F,
    32'hFFFF_8000, 32'hFF80_0000, 32'd12345678
  };

  localparam logic [31:0] DVS [11] = '{
    32'd0, 32'd1, 32'd2, 32'd3, 32'd7, 32'd255, 32'd1000, 32'h0001_0000,
    32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'h8000_0000
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
    chk(rsp_quotient == 32'd0 && rsp_remainder == 32'd0, "R1 results", rsp_quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R3, R4, R5, R6, R9: sweep of class boundaries in both modes
    for (int sg = 0; sg < 2; sg++) begin
      for (int i = 0; i < 22; i++) begin
        for (int j = 0; j < 11; j++) begin
          one_div(DVD[i], DVS[j], sg[0]);
        end
      end
    end

    // R7: requests held behind a running divide
    back_to_back(32'd1000, 32'd7, 32'hFFFF_FFFF, 32'd3, 1'b0);
    back_to_back(32'hFFFF_FF9C, 32'd7, 32'd5000000, 32'hFFFF_FFFE, 1'b1);
    back_to_back(32'h8000_0000, 32'hFFFF_FFFF, 32'd9, 32'd0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule